// File: doc/BRIEF.md
# Butterfly RAM Test Sequencer

This block runs a butterfly pattern test over a bit-wide RAM whose cells form a grid of rows and columns, each dimension a power of two. A pulse on `start` launches the test. The block fills the whole array with a background value. It then visits every cell in turn as the base cell. For each base cell it writes the inverted background into that cell. It reads nearby cells that lie at power-of-two distances along the four compass directions, and reads the base cell again after each group of four. It then writes the background back into the base cell. The whole pass is done first with a background of 0 and then with a background of 1.

The block drives the RAM address, write enable, read enable and write data, and compares the returned read data against the value each read should see. The first read that disagrees sets a sticky fail flag and captures the row and column of that cell. The test keeps running to the end, so the total run time does not depend on the result. When the second pass ends the block raises `done` and holds it until the next start.

Top module: `bfly_mem_test`

## Requirements
- R1: After reset `done`, `fail`, `mem_we`, `mem_re`, `fail_row` and `fail_col` are all 0.
- R2: Each pass begins with one write per cycle of the pass background to every cell, in row-major order: the row is the upper ROW_BITS of a linear index counting up from 0, and the column is the lower COL_BITS.
- R3: After the fill, the base cells are visited in the same row-major order. For each base cell there is one cycle that writes the inverted background to it. Then come DIST_STEPS groups with distance d = 1, 2, 4, and so on. Each group has five slots in this order: row-d (north), column+d (east), row+d (south), column-d (west), then the base cell. After the last group there is one cycle that writes the background back to the base cell.
- R4: A slot whose neighbour falls outside the array is not wrapped. It takes one cycle with both `mem_we` and `mem_re` low.
- R5: Read data is taken one cycle after the read is presented. A neighbour read must return the pass background. A base cell read must return its inverse. Cells that are not on a compass line from a base cell are never read while that base cell is inverted.
- R6: The pass with background 0 is followed by the pass with background 1. `done` rises exactly 2·N·(3+5·DIST_STEPS) cycles after the cycle in which `start` is accepted, where N is the number of cells.
- R7: `fail` rises two cycles after the first mismatching read is presented. `fail_row` and `fail_col` hold that read's coordinates, and later mismatches change neither the flag nor the coordinates.
- R8: `start` is ignored while a test is running. When idle or done, `start` clears `done`, `fail` and the captured coordinates and begins a new test.
- R9: `mem_we` and `mem_re` are never high in the same cycle.
- R10: While `done` is high and `start` is low, `done` stays high and no access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a test when idle or done |
| mem_row | output | ROW_BITS | Row address to the RAM |
| mem_col | output | COL_BITS | Column address to the RAM |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data, valid one cycle after a read |
| done | output | 1 | Test complete, held until next start |
| fail | output | 1 | Sticky mismatch flag |
| fail_row | output | ROW_BITS | Row of the first mismatch |
| fail_col | output | COL_BITS | Column of the first mismatch |

## Verification
The sequencer's state can go wrong in several ways: a bad counter, a wrong slot order, a wrong distance, or a wrong edge test. Any of these shows up in the very cycle it happens as a wrong address or enable at the RAM port. For that reason the bench predicts every cycle of the access stream from nested loops and compares it cycle by cycle. A wrong expected value or a broken compare path shows up only through `fail`, two cycles after the read concerned. The bench therefore injects a stuck cell and coupling faults into its RAM model. It predicts from its own model which read mismatches first, then checks the fail timing and the captured coordinates against that prediction. A coupling victim that is off the compass lines must leave `fail` low.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FILL    = 3'd1,
    ST_FLIP    = 3'd2,
    ST_PROBE   = 3'd3,
    ST_RESTORE = 3'd4,
    ST_FIN     = 3'd5
  } bfly_state_e;

  // slot order within one distance group; behaviour depends on this order
  typedef enum logic [2:0] {
    SL_NORTH = 3'd0,
    SL_EAST  = 3'd1,
    SL_SOUTH = 3'd2,
    SL_WEST  = 3'd3,
    SL_BASE  = 3'd4
  } bfly_slot_e;

  function automatic int step_dist(int k);
    return 1 << k;
  endfunction

  function automatic int probe_row(int r, int d, bfly_slot_e s);
    case (s)
      SL_NORTH: return r - d;
      SL_SOUTH: return r + d;
      default:  return r;
    endcase
  endfunction

  function automatic int probe_col(int c, int d, bfly_slot_e s);
    case (s)
      SL_EAST: return c + d;
      SL_WEST: return c - d;
      default: return c;
    endcase
  endfunction

  function automatic bit probe_ok(int r, int c, int d, bfly_slot_e s,
                                  int rows, int cols);
    case (s)
      SL_NORTH: return r >= d;
      SL_EAST:  return (c + d) < cols;
      SL_SOUTH: return (r + d) < rows;
      SL_WEST:  return c >= d;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/bfly_seq_ctrl.sv
module bfly_seq_ctrl
  import bfly_pkg::*;
#(
  parameter int ROW_BITS   = 3,
  parameter int COL_BITS   = 3,
  parameter int DIST_STEPS = 2,
  localparam int STEP_W    = (DIST_STEPS > 1) ? $clog2(DIST_STEPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output bfly_state_e         state,
  output logic                bg,
  output logic [ROW_BITS-1:0] base_row,
  output logic [COL_BITS-1:0] base_col,
  output logic [STEP_W-1:0]   step,
  output bfly_slot_e          slot,
  output logic                launch
);

  localparam int CELL_BITS = ROW_BITS + COL_BITS;

  bfly_state_e          state_q;
  logic                 bg_q;
  logic [CELL_BITS-1:0] cell_q;
  logic [STEP_W-1:0]    step_q;
  bfly_slot_e           slot_q;
  logic                 last_cell;
  logic                 last_step;

  assign last_cell = &cell_q;
  assign last_step = (step_q == STEP_W'(DIST_STEPS - 1));
  assign launch    = start && ((state_q == ST_IDLE) || (state_q == ST_FIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bg_q    <= 1'b0;
      cell_q  <= '0;
      step_q  <= '0;
      slot_q  <= SL_NORTH;
    end else begin
      case (state_q)
        ST_IDLE, ST_FIN: begin
          if (launch) begin
            state_q <= ST_FILL;
            bg_q    <= 1'b0;
            cell_q  <= '0;
          end
        end
        ST_FILL: begin
          cell_q <= cell_q + 1'b1;
          if (last_cell) state_q <= ST_FLIP;
        end
        ST_FLIP: begin
          step_q  <= '0;
          slot_q  <= SL_NORTH;
          state_q <= ST_PROBE;
        end
        ST_PROBE: begin
          if (slot_q == SL_BASE) begin
            slot_q <= SL_NORTH;
            if (last_step) state_q <= ST_RESTORE;
            else           step_q  <= step_q + 1'b1;
          end else begin
            slot_q <= bfly_slot_e'(slot_q + 3'd1);
          end
        end
        ST_RESTORE: begin
          cell_q <= cell_q + 1'b1;
          if (!last_cell)  state_q <= ST_FLIP;
          else if (bg_q)   state_q <= ST_FIN;
          else begin
            bg_q    <= 1'b1;
            state_q <= ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state    = state_q;
  assign bg       = bg_q;
  assign base_row = cell_q[CELL_BITS-1:COL_BITS];
  assign base_col = cell_q[COL_BITS-1:0];
  assign step     = step_q;
  assign slot     = slot_q;

endmodule

// File: rtl/bfly_port_drive.sv
module bfly_port_drive
  import bfly_pkg::*;
#(
  parameter int ROW_BITS   = 3,
  parameter int COL_BITS   = 3,
  parameter int DIST_STEPS = 2,
  localparam int STEP_W    = (DIST_STEPS > 1) ? $clog2(DIST_STEPS) : 1
) (
  input  bfly_state_e         state,
  input  logic                bg,
  input  logic [ROW_BITS-1:0] base_row,
  input  logic [COL_BITS-1:0] base_col,
  input  logic [STEP_W-1:0]   step,
  input  bfly_slot_e          slot,
  output logic [ROW_BITS-1:0] mem_row,
  output logic [COL_BITS-1:0] mem_col,
  output logic                mem_we,
  output logic                mem_re,
  output logic                mem_wdata,
  output logic                exp_bit
);

  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  int   br, bc, dd, nr, nc;
  logic nb_ok;

  assign br    = int'(base_row);
  assign bc    = int'(base_col);
  assign dd    = step_dist(int'(step));
  assign nr    = probe_row(br, dd, slot);
  assign nc    = probe_col(bc, dd, slot);
  assign nb_ok = probe_ok(br, bc, dd, slot, ROWS, COLS);

  always_comb begin
    mem_row   = '0;
    mem_col   = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = 1'b0;
    exp_bit   = 1'b0;
    case (state)
      ST_FILL, ST_RESTORE: begin
        mem_we    = 1'b1;
        mem_row   = base_row;
        mem_col   = base_col;
        mem_wdata = bg;
      end
      ST_FLIP: begin
        mem_we    = 1'b1;
        mem_row   = base_row;
        mem_col   = base_col;
        mem_wdata = ~bg;
      end
      ST_PROBE: begin
        if (slot == SL_BASE) begin
          mem_re  = 1'b1;
          mem_row = base_row;
          mem_col = base_col;
          exp_bit = ~bg;
        end else if (nb_ok) begin
          mem_re  = 1'b1;
          mem_row = ROW_BITS'(nr);
          mem_col = COL_BITS'(nc);
          exp_bit = bg;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bfly_resp_check.sv
module bfly_resp_check #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                mem_re,
  input  logic                exp_bit,
  input  logic [ROW_BITS-1:0] mem_row,
  input  logic [COL_BITS-1:0] mem_col,
  input  logic                mem_rdata,
  output logic                fail,
  output logic [ROW_BITS-1:0] fail_row,
  output logic [COL_BITS-1:0] fail_col,
  output logic                rd_mismatch
);

  logic                rd_q;
  logic                exp_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;

  assign rd_mismatch = rd_q && (mem_rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      exp_q <= 1'b0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      rd_q  <= mem_re;
      exp_q <= exp_bit;
      row_q <= mem_row;
      col_q <= mem_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      fail_row <= '0;
      fail_col <= '0;
    end else if (clear) begin
      fail     <= 1'b0;
      fail_row <= '0;
      fail_col <= '0;
    end else if (rd_mismatch && !fail) begin
      fail     <= 1'b1;
      fail_row <= row_q;
      fail_col <= col_q;
    end
  end

endmodule

// File: rtl/bfly_mem_test.sv
module bfly_mem_test
  import bfly_pkg::*;
#(
  parameter int ROW_BITS   = 3,
  parameter int COL_BITS   = 3,
  parameter int DIST_STEPS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic [ROW_BITS-1:0] mem_row,
  output logic [COL_BITS-1:0] mem_col,
  output logic                mem_we,
  output logic                mem_re,
  output logic                mem_wdata,
  input  logic                mem_rdata,
  output logic                done,
  output logic                fail,
  output logic [ROW_BITS-1:0] fail_row,
  output logic [COL_BITS-1:0] fail_col
);

  localparam int STEP_W = (DIST_STEPS > 1) ? $clog2(DIST_STEPS) : 1;

  bfly_state_e         state;
  bfly_slot_e          slot;
  logic                bg;
  logic [ROW_BITS-1:0] base_row;
  logic [COL_BITS-1:0] base_col;
  logic [STEP_W-1:0]   step;
  logic                launch;
  logic                exp_bit;
  logic                busy;
  logic                rd_mismatch;

  bfly_seq_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DIST_STEPS(DIST_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state), .bg(bg),
    .base_row(base_row), .base_col(base_col), .step(step), .slot(slot),
    .launch(launch)
  );

  bfly_port_drive #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DIST_STEPS(DIST_STEPS)) u_drive (
    .state(state), .bg(bg), .base_row(base_row), .base_col(base_col),
    .step(step), .slot(slot), .mem_row(mem_row), .mem_col(mem_col),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .exp_bit(exp_bit)
  );

  bfly_resp_check #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_check (
    .clk(clk), .rst_n(rst_n), .clear(launch), .mem_re(mem_re),
    .exp_bit(exp_bit), .mem_row(mem_row), .mem_col(mem_col),
    .mem_rdata(mem_rdata), .fail(fail), .fail_row(fail_row),
    .fail_col(fail_col), .rd_mismatch(rd_mismatch)
  );

  assign done = (state == ST_FIN);
  assign busy = (state != ST_IDLE) && (state != ST_FIN);

endmodule

// File: rtl/bfly_mem_test_chk.sv
module bfly_mem_test_chk #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                fail,
  input logic [ROW_BITS-1:0] fail_row,
  input logic [COL_BITS-1:0] fail_col,
  input logic                mem_we,
  input logic                mem_re,
  input logic                rd_mismatch
);

  a_r9_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r7_mismatch_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mismatch |=> fail);

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  a_r7_coords_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> ($stable(fail_row) && $stable(fail_col)));

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !mem_we && !mem_re));

  a_r8_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && !fail));

  a_r6_done_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_we));

endmodule

bind bfly_mem_test bfly_mem_test_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .fail_row(fail_row), .fail_col(fail_col),
  .mem_we(mem_we), .mem_re(mem_re), .rd_mismatch(rd_mismatch)
);

// File: tb/tb_bfly_mem_test.sv
`timescale 1ns/1ps
module tb_bfly_mem_test;

  localparam int RB    = 3;
  localparam int CB    = 3;
  localparam int STEPS = 2;
  localparam int ROWS  = 1 << RB;
  localparam int COLS  = 1 << CB;
  localparam int NC    = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RB-1:0] mem_row;
  logic [CB-1:0] mem_col;
  logic          mem_we, mem_re, mem_wdata;
  logic          mem_rdata;
  logic          done, fail;
  logic [RB-1:0] fail_row;
  logic [CB-1:0] fail_col;

  int checks = 0;
  int errors = 0;
  int prints = 0;

  // RAM model with fault injection: 0 none, 1 stuck cell, 2 inversion coupling
  logic mem [NC];
  int   fmode = 0;
  int   f_idx = 0;
  logic f_val = 1'b0;
  int   agg_idx = 0;
  int   vic_idx = 0;

  // run bookkeeping
  int   cyc;
  int   poke_at;
  bit   have_ff;
  int   ff_cyc, ff_r, ff_c;

  always #2.5 clk = ~clk;

  bfly_mem_test #(.ROW_BITS(RB), .COL_BITS(CB), .DIST_STEPS(STEPS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_row(mem_row), .mem_col(mem_col),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_row(fail_row), .fail_col(fail_col)
  );

  function automatic logic view(int idx);
    if (fmode == 1 && idx == f_idx) return f_val;
    return mem[idx];
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      int wi;
      wi = int'(mem_row) * COLS + int'(mem_col);
      mem[wi] <= mem_wdata;
      if (fmode == 2 && wi == agg_idx && mem[wi] != mem_wdata)
        mem[vic_idx] <= ~mem[vic_idx];
    end
    if (mem_re) mem_rdata <= view(int'(mem_row) * COLS + int'(mem_col));
  end

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      if (prints < 20) begin
        prints++;
        $display("FAIL %s cyc=%0d %s", tag, cyc, msg);
      end
    end
  endtask

  // compare one cycle of port activity, then move to the next negedge
  task automatic expect_op(input bit xwe, input bit xre, input int xr, input int xc,
                           input logic xwd, input logic xexp, input string tag);
    bit ok;
    bit xfail;
    ok = (mem_we == xwe) && (mem_re == xre);
    if (xwe || xre) ok = ok && (int'(mem_row) == xr) && (int'(mem_col) == xc);
    if (xwe) ok = ok && (mem_wdata == xwd);
    check(ok, tag, $sformatf("act we=%0b re=%0b r=%0d c=%0d wd=%0b exp we=%0b re=%0b r=%0d c=%0d wd=%0b",
          mem_we, mem_re, mem_row, mem_col, mem_wdata, xwe, xre, xr, xc, xwd));
    if (xre && !have_ff && view(xr * COLS + xc) !== xexp) begin
      have_ff = 1; ff_cyc = cyc; ff_r = xr; ff_c = xc;
    end
    xfail = have_ff && (cyc >= ff_cyc + 2);
    check(fail == xfail, "R7", $sformatf("fail act %0b exp %0b", fail, xfail));
    cyc++;
    start = (cyc == poke_at);
    @(negedge clk);
  endtask

  task automatic run_test(input int poke, input bit xbg1_end);
    have_ff = 0;
    poke_at = poke;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int bgv = 0; bgv < 2; bgv++) begin
      for (int i = 0; i < NC; i++)
        expect_op(1, 0, i / COLS, i % COLS, logic'(bgv), 1'b0, "R2");
      for (int i = 0; i < NC; i++) begin
        int r, c;
        r = i / COLS; c = i % COLS;
        expect_op(1, 0, r, c, ~logic'(bgv), 1'b0, "R3");
        for (int k = 0; k < STEPS; k++) begin
          int d;
          d = 1 << k;
          for (int s = 0; s < 4; s++) begin
            int nr, nc;
            bit ok;
            nr = r; nc = c;
            case (s)
              0: nr = r - d;
              1: nc = c + d;
              2: nr = r + d;
              default: nc = c - d;
            endcase
            ok = (nr >= 0) && (nr < ROWS) && (nc >= 0) && (nc < COLS);
            if (ok) expect_op(0, 1, nr, nc, 1'b0, logic'(bgv), "R3");
            else    expect_op(0, 0, 0, 0, 1'b0, 1'b0, "R4");
          end
          expect_op(0, 1, r, c, 1'b0, ~logic'(bgv), "R5");
        end
        expect_op(1, 0, r, c, logic'(bgv), 1'b0, "R3");
      end
    end
    start = 1'b0;
    check(cyc == 2 * NC * (3 + 5 * STEPS), "R6",
          $sformatf("cycles act %0d exp %0d", cyc, 2 * NC * (3 + 5 * STEPS)));
    check(done == 1'b1, "R6", $sformatf("done act %0b exp 1", done));
    check(fail == have_ff, "R7", $sformatf("final fail act %0b exp %0b", fail, have_ff));
    if (have_ff)
      check(int'(fail_row) == ff_r && int'(fail_col) == ff_c, "R7",
            $sformatf("coord act %0d,%0d exp %0d,%0d", fail_row, fail_col, ff_r, ff_c));
    if (xbg1_end) begin
      bit all1;
      all1 = 1;
      for (int i = 0; i < NC; i++) if (mem[i] !== 1'b1) all1 = 0;
      check(all1, "R3", "array not left at background 1 after restores");
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(done && !mem_we && !mem_re, "R10",
            $sformatf("done=%0b we=%0b re=%0b exp 1 0 0", done, mem_we, mem_re));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !fail && !mem_we && !mem_re && fail_row == '0 && fail_col == '0, "R1",
          $sformatf("reset done=%0b fail=%0b we=%0b re=%0b", done, fail, mem_we, mem_re));
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_we && !mem_re, "R1", "idle after reset release");

    // clean array, with a stray start mid-run (R8: ignored)
    fmode = 0;
    run_test(100, 1);

    // stuck-at-1 cell, restarted straight from done (R8 clear)
    fmode = 1; f_idx = 5 * COLS + 2; f_val = 1'b1;
    run_test(-1, 0);

    // stuck-at-0 on a corner: base read fails first, later mismatches ignored (R7)
    fmode = 1; f_idx = NC - 1; f_val = 1'b0;
    run_test(-1, 0);

    // inversion coupling onto a north neighbour: detected (R5)
    fmode = 2; agg_idx = 3 * COLS + 3; vic_idx = 2 * COLS + 3;
    run_test(-1, 0);

    // inversion coupling onto a diagonal cell: never read while inverted (R5)
    fmode = 2; agg_idx = 3 * COLS + 3; vic_idx = 4 * COLS + 4;
    run_test(700, 0);
    check(!fail, "R5", $sformatf("diagonal victim fail act %0b exp 0", fail));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule